// File: doc/BRIEF.md
# Dual-Mode Pulse Counter Digitizer

This block turns a stream of single-cycle event strobes into 15-bit binary words. One shared saturating counter serves both modes, and the `mode_i` pin picks what feeds it. With `mode_i` = 0 (signal mode) the counter accumulates quantizer pulses on `pulse_i` inside a counting window. The window is opened by `win_start_i` and lasts `win_len_i` cycles. The result is proportional to the pulse rate, or to the total charge of a burst that falls inside the window. With `mode_i` = 1 (time mode) the counter accumulates reference-clock enables on `ref_tick_i`. Every `hit_i` strobe captures the running count as a time stamp.

Finished words wait in a four-entry shift-register buffer, so several stamps taken between readouts are kept. The words leave bit-serially over a valid/ready stream, most significant bit first. A word leaves the buffer only after all 15 of its bits have been accepted. The sink may hold `ser_ready_i` low at any time, and the current bit is then held with `ser_valid_o` high. Each word carries a saturation flag on `ser_sat_o`. A sticky `ovf_o` flag reports words that were dropped because the buffer was full. Changing the mode restarts everything.

Top module: `pulse_digitizer`

## Requirements
- R1: After reset `ser_valid_o` and `ovf_o` are 0, and the block is in signal mode with no window open.
- R2: In signal mode, `win_start_i` sampled high with `win_len_i` = L > 0 while no window is open clears the counter. The `pulse_i` values sampled on the next L edges are then counted. A pulse on the start edge or after the window is not counted. The word is pushed on the last window edge and shows on `ser_valid_o` just after that edge. A start while a window is open, or a start with L = 0, is ignored.
- R3: In time mode the counter counts `ref_tick_i` on every edge since the mode was entered. A `hit_i` sampled on edge E stores the number of ticks sampled on edges before E.
- R4: The counter stops at 32767 (all 15 bits set) instead of wrapping. A word's saturation flag is 1 exactly when an increment was lost at that value. A time-mode stamp of 16000 ticks is exact, with the flag at 0.
- R5: The buffer holds 4 words in arrival order. A word pushed while 4 words are waiting and none leaves in that cycle is dropped, and this sets `ovf_o`, which stays 1 until the next mode change.
- R6: Each word is sent as bit 14 first, down to bit 0. `ser_sat_o` stays constant for the whole word. With `ser_ready_i` held high, `ser_valid_o` stays high for exactly 15 consecutive cycles for each word.
- R7: While `ser_valid_o` is high and `ser_ready_i` is low, `ser_valid_o`, `ser_data_o` and `ser_sat_o` hold their values on the next cycle.
- R8: A change of `mode_i` clears the counter, any open window, the buffer, the serializer position and `ovf_o`. In the cycle after the change, `ser_valid_o` and `ovf_o` are 0.
- R9: In signal mode `ref_tick_i` and `hit_i` have no effect. In time mode `pulse_i` and `win_start_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = signal (pulse count) mode, 1 = time (stamp) mode |
| pulse_i | input | 1 | Quantizer pulse strobe, one per cycle at most |
| ref_tick_i | input | 1 | Reference-clock enable, one tick per cycle at most |
| hit_i | input | 1 | Hit strobe that captures a time stamp |
| win_start_i | input | 1 | Opens a counting window in signal mode |
| win_len_i | input | WIN_W | Counting window length in cycles |
| ser_data_o | output | 1 | Serial data bit, MSB first |
| ser_sat_o | output | 1 | Saturation flag of the word being sent |
| ser_valid_o | output | 1 | Serial bit valid |
| ser_ready_i | input | 1 | Sink accepts the bit on this edge |
| ovf_o | output | 1 | Sticky flag: a word was dropped on a full buffer |

## Verification
A word is due on `ser_valid_o` one cycle after the edge that samples its last window pulse or its hit. Its bits then follow one per accepted edge. The effect of a mode change shows one cycle after the edge that sees the new mode. The bench drives every input and samples every output on falling clock edges, so each check falls exactly one edge after its stimulus. The bench counts window and hit edges itself when it checks the first cycle of `ser_valid_o` and the cycle in which `ovf_o` rises. Words are read only after the stimulus has finished, with the sink held off until then, so buffer contents and drops follow from the count of pushes alone.

// File: rtl/dig_pkg.sv
package dig_pkg;
  // Width of the shared binary counter and of each output word.
  localparam int CNT_W = 15;

  typedef struct packed {
    logic             sat;
    logic [CNT_W-1:0] value;
  } stamp_t;
endpackage

// File: rtl/dig_counter.sv
module dig_counter #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         sat_o,
  output logic [W-1:0] acc_cnt_o,
  output logic         acc_sat_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;
  logic         sat_q;
  logic         at_top;

  assign at_top    = (cnt_q == TOP);
  assign acc_cnt_o = (inc_i && !at_top) ? cnt_q + W'(1) : cnt_q;
  assign acc_sat_o = sat_q | (inc_i & at_top);
  assign cnt_o     = cnt_q;
  assign sat_o     = sat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else begin
      cnt_q <= acc_cnt_o;
      sat_q <= acc_sat_o;
    end
  end
endmodule

// File: rtl/dig_window.sv
module dig_window #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort_i,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  output logic         active_o,
  output logic         last_o
);
  logic [W-1:0] rem_q;

  assign active_o = (rem_q != '0);
  assign last_o   = (rem_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (abort_i) begin
      rem_q <= '0;
    end else if (active_o) begin
      rem_q <= rem_q - W'(1);
    end else if (start_i && (len_i != '0)) begin
      rem_q <= len_i;
    end
  end
endmodule

// File: rtl/dig_shift_buf.sv
module dig_shift_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         drop_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] fill_q;
  logic          full;
  logic          do_pop;
  logic          do_push;
  logic [CW-1:0] wr_idx;

  assign empty_o = (fill_q == '0);
  assign full    = (fill_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign drop_o  = push_i && !do_push;
  assign wr_idx  = do_pop ? fill_q - CW'(1) : fill_q;
  assign head_o  = mem_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (do_push && (wr_idx == CW'(i))) begin
        mem_q[i] <= data_i;
      end else if (do_pop) begin
        if (i == DEPTH - 1) mem_q[i] <= mem_q[i];
        else                mem_q[i] <= mem_q[(i + 1) % DEPTH];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (flush_i) begin
      fill_q <= '0;
    end else begin
      case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + CW'(1);
        2'b01:   fill_q <= fill_q - CW'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/dig_p2s.sv
module dig_p2s #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         avail_i,
  input  logic [W-1:0] word_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic         data_o,
  output logic         done_o
);
  localparam int IW = $clog2(W);

  logic [IW-1:0] idx_q;
  logic          fire;
  logic          at_end;

  assign valid_o = avail_i;
  assign data_o  = word_i[IW'(W - 1) - idx_q];
  assign fire    = avail_i && ready_i;
  assign at_end  = (idx_q == IW'(W - 1));
  assign done_o  = fire && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (flush_i) begin
      idx_q <= '0;
    end else if (fire) begin
      idx_q <= at_end ? '0 : idx_q + IW'(1);
    end
  end
endmodule

// File: rtl/pulse_digitizer.sv
module pulse_digitizer
  import dig_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             pulse_i,
  input  logic             ref_tick_i,
  input  logic             hit_i,
  input  logic             win_start_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             ser_data_o,
  output logic             ser_sat_o,
  output logic             ser_valid_o,
  input  logic             ser_ready_i,
  output logic             ovf_o
);
  localparam int WORD_W = $bits(stamp_t);

  logic             mode_q;
  logic             mode_chg;
  logic             time_mode;
  logic             win_active;
  logic             win_last;
  logic [CNT_W-1:0] cnt;
  logic             sat;
  logic [CNT_W-1:0] acc_cnt;
  logic             acc_sat;
  logic             inc;
  logic             clr;
  logic             push;
  stamp_t           push_word;
  stamp_t           head;
  logic             empty;
  logic             drop;
  logic             pop;
  logic             ovf_q;

  assign mode_chg  = (mode_i != mode_q);
  assign time_mode = mode_q;

  // Source routing: exactly one event stream feeds the counter.
  assign inc = !mode_chg && (time_mode ? ref_tick_i : (pulse_i && win_active));
  assign clr = mode_chg ||
               (!time_mode && win_start_i && !win_active && (win_len_i != '0));

  assign push = !mode_chg && (time_mode ? hit_i : win_last);
  always_comb begin
    if (time_mode) begin
      push_word.sat   = sat;
      push_word.value = cnt;
    end else begin
      push_word.sat   = acc_sat;
      push_word.value = acc_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (mode_chg)  ovf_q <= 1'b0;
      else if (drop) ovf_q <= 1'b1;
    end
  end

  dig_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .inc_i     (inc),
    .cnt_o     (cnt),
    .sat_o     (sat),
    .acc_cnt_o (acc_cnt),
    .acc_sat_o (acc_sat)
  );

  dig_window #(.W(WIN_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_i  (mode_chg),
    .start_i  (win_start_i && !time_mode),
    .len_i    (win_len_i),
    .active_o (win_active),
    .last_o   (win_last)
  );

  dig_shift_buf #(.DEPTH(DEPTH), .W(WORD_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (mode_chg),
    .push_i  (push),
    .data_i  (push_word),
    .pop_i   (pop && !mode_chg),
    .head_o  (head),
    .empty_o (empty),
    .drop_o  (drop)
  );

  dig_p2s #(.W(CNT_W)) u_p2s (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (mode_chg),
    .avail_i (!empty),
    .word_i  (head.value),
    .ready_i (ser_ready_i),
    .valid_o (ser_valid_o),
    .data_o  (ser_data_o),
    .done_o  (pop)
  );

  assign ser_sat_o = head.sat;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/dig_checker.sv
module dig_checker (
  input logic clk,
  input logic rst_n,
  input logic mode_i,
  input logic mode_q_i,
  input logic ser_valid_o,
  input logic ser_ready_i,
  input logic ser_data_o,
  input logic ser_sat_o,
  input logic ovf_o
);
  localparam int FRAME = dig_pkg::CNT_W;

  logic       chg;
  logic [4:0] beats_q;

  assign chg = (mode_i != mode_q_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         beats_q <= '0;
    else if (chg)                       beats_q <= '0;
    else if (ser_valid_o && ser_ready_i)
      beats_q <= (beats_q == 5'(FRAME - 1)) ? '0 : beats_q + 5'd1;
  end

  // R7: a stalled bit is held steady
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_o && !ser_ready_i && !chg) |=>
      (ser_valid_o && $stable(ser_data_o) && $stable(ser_sat_o)));

  // R5: the drop flag is sticky until a mode change
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !chg) |=> ovf_o);

  // R8: a mode change empties the stream and clears the flag
  assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (!ser_valid_o && !ovf_o));

  // R6: a word in flight does not lose valid before its last bit
  assert_frame_continuous_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_o && ser_ready_i && !chg && (beats_q != 5'(FRAME - 1))) |=> ser_valid_o);

  // R6: saturation flag constant within a word
  assert_sat_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_o && !chg && (beats_q != 5'd0)) |-> ($stable(ser_sat_o) || !$past(ser_valid_o)));
endmodule

bind pulse_digitizer dig_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .mode_q_i    (mode_q),
  .ser_valid_o (ser_valid_o),
  .ser_ready_i (ser_ready_i),
  .ser_data_o  (ser_data_o),
  .ser_sat_o   (ser_sat_o),
  .ovf_o       (ovf_o)
);

// File: tb/sim_pulse_digitizer.sv
`timescale 1ns/1ps
module sim_pulse_digitizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        pulse = 1'b0;
  logic        ref_tick = 1'b0;
  logic        hit = 1'b0;
  logic        win_start = 1'b0;
  logic [15:0] win_len = '0;
  logic        ser_data;
  logic        ser_sat;
  logic        ser_valid;
  logic        ser_ready = 1'b0;
  logic        ovf;

  int checks = 0;
  int errs   = 0;

  always #2.5 clk = ~clk;

  pulse_digitizer u0 (
    .clk (clk), .rst_n (rst_n), .mode_i (mode), .pulse_i (pulse),
    .ref_tick_i (ref_tick), .hit_i (hit), .win_start_i (win_start),
    .win_len_i (win_len), .ser_data_o (ser_data), .ser_sat_o (ser_sat),
    .ser_valid_o (ser_valid), .ser_ready_i (ser_ready), .ovf_o (ovf)
  );

  task automatic chk_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic get_word(output int w, output int s, input int stall_at);
    int guard = 0;
    ser_ready = 1'b1;
    while (!ser_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    w = 0;
    s = int'(ser_sat);
    chk_eq("R6 word present", int'(ser_valid), 1);
    for (int b = 0; b < 15; b++) begin
      if (b == stall_at) begin
        int d0 = int'(ser_data);
        ser_ready = 1'b0;
        repeat (3) begin
          @(negedge clk);
          chk_eq("R7 valid held", int'(ser_valid), 1);
          chk_eq("R7 data held", int'(ser_data), d0);
        end
        ser_ready = 1'b1;
      end
      if (!ser_valid) chk_eq("R6 valid in frame", 0, 1);
      if (int'(ser_sat) != s) chk_eq("R6 sat steady", int'(ser_sat), s);
      w = (w << 1) | int'(ser_data);
      @(negedge clk);
    end
    ser_ready = 1'b0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk);
    pulse = 0; ref_tick = 0; hit = 0; win_start = 0;
    mode = m;
    @(negedge clk);
    chk_eq("R8 valid after mode change", int'(ser_valid), 0);
    chk_eq("R8 ovf after mode change", int'(ovf), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 valid after reset", int'(ser_valid), 0);
    chk_eq("R1 ovf after reset", int'(ovf), 0);
  endtask

  task automatic t_signal_rate();
    int w, s;
    @(negedge clk);
    win_start = 1; win_len = 16'd20; pulse = 1;   // start-edge pulse excluded
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 20) chk_eq("R2 no word before last edge", int'(ser_valid), 0);
      win_start = (k == 5);                        // ignored: window open
      win_len   = (k == 5) ? 16'd3 : 16'd20;
      pulse     = k[0];
      hit       = (k == 3);                        // R9 ignored in signal mode
      ref_tick  = 1;
    end
    @(negedge clk);
    chk_eq("R2 word right after last edge", int'(ser_valid), 1);
    pulse = 1; hit = 0; ref_tick = 0; win_start = 0;
    repeat (3) @(negedge clk);
    pulse = 0;
    get_word(w, s, -1);
    chk_eq("R2 rate count", w, 10);
    chk_eq("R4 sat clear on rate word", s, 0);
    chk_eq("R6 valid ends after 15 bits", int'(ser_valid), 0);
    chk_eq("R9 hit ignored in signal mode", int'(ser_valid), 0);
    // zero length start is ignored
    win_start = 1; win_len = 16'd0;
    @(negedge clk);
    win_start = 0; pulse = 1;
    repeat (5) @(negedge clk);
    pulse = 0;
    chk_eq("R2 zero-length start ignored", int'(ser_valid), 0);
  endtask

  task automatic t_signal_burst();
    int w, s;
    @(negedge clk);
    win_start = 1; win_len = 16'd50;
    for (int k = 1; k <= 50; k++) begin
      @(negedge clk);
      win_start = 0;
      pulse = (k >= 10 && k < 30);
    end
    @(negedge clk);
    pulse = 0;
    get_word(w, s, 7);
    chk_eq("R2 burst charge count", w, 20);
    chk_eq("R7 word intact after stall", w, 20);
  endtask

  task automatic t_time();
    int w, s;
    set_mode(1);
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      ref_tick = 1;
      hit = (i == 5 || i == 12 || i == 40);
      pulse = 1;                  // R9 ignored in time mode
      win_start = (i == 2); win_len = 16'd3;
    end
    @(negedge clk);
    ref_tick = 0; hit = 0; pulse = 0; win_start = 0;
    get_word(w, s, -1); chk_eq("R3 first stamp", w, 4);
    get_word(w, s, -1); chk_eq("R3 second stamp", w, 11);
    get_word(w, s, -1); chk_eq("R3 third stamp", w, 39);
    chk_eq("R9 window ignored in time mode", int'(ser_valid), 0);
  endtask

  task automatic t_long();
    int w, s;
    set_mode(0);
    set_mode(1);
    for (int i = 1; i <= 16001; i++) begin
      @(negedge clk);
      ref_tick = 1;
      hit = (i == 16001);
    end
    @(negedge clk);
    ref_tick = 0; hit = 0;
    get_word(w, s, -1);
    chk_eq("R4 16000 tick stamp", w, 16000);
    chk_eq("R4 no sat at 16000", s, 0);
  endtask

  task automatic t_overflow();
    int w, s;
    set_mode(0);
    set_mode(1);
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (i == 9)  chk_eq("R5 no drop with 4 words", int'(ovf), 0);
      if (i == 11) chk_eq("R5 drop sets ovf", int'(ovf), 1);
      ref_tick = 1;
      hit = (i <= 12) && !i[0];
    end
    @(negedge clk);
    ref_tick = 0; hit = 0;
    get_word(w, s, -1); chk_eq("R5 order word 1", w, 1);
    get_word(w, s, -1); chk_eq("R5 order word 2", w, 3);
    get_word(w, s, -1); chk_eq("R5 order word 3", w, 5);
    get_word(w, s, -1); chk_eq("R5 order word 4", w, 7);
    chk_eq("R5 dropped words absent", int'(ser_valid), 0);
    chk_eq("R5 ovf sticky", int'(ovf), 1);
    hit = 1;
    repeat (2) @(negedge clk);
    hit = 0;
    chk_eq("R8 words pending before change", int'(ser_valid), 1);
    set_mode(0);
  endtask

  task automatic t_saturate();
    int w, s;
    @(negedge clk);
    win_start = 1; win_len = 16'd33000;
    @(negedge clk);
    win_start = 0; pulse = 1;
    repeat (33002) @(negedge clk);
    pulse = 0;
    get_word(w, s, -1);
    chk_eq("R4 saturated value", w, 32767);
    chk_eq("R4 sat flag set", s, 1);
    win_start = 1; win_len = 16'd100;
    @(negedge clk);
    win_start = 0; pulse = 1;
    repeat (101) @(negedge clk);
    pulse = 0;
    get_word(w, s, -1);
    chk_eq("R4 count after restart", w, 100);
    chk_eq("R4 sat cleared by new window", s, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_signal_rate();
    t_signal_burst();
    t_time();
    t_long();
    t_overflow();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule